// File: doc/BRIEF.md
# Flash Write-Command Decoder with Fast Program Mode

This block is the device-side command logic of a small NOR-style flash word array. A host issues write cycles (write strobe, bus address, data word). The block decodes these into commands, runs a timed internal program or erase-all operation on its array, and shows progress on a busy flag and an error flag. A separate read port returns stored words one clock after the address is presented, in every mode. Command bytes are taken from the low 8 bits of the data word. The array word is chosen by the low `ARR_AW` bits of the bus address.

The normal program command needs two unlock writes, a program command write and an address/data write. A fast mode trims this to two writes per word. It is entered either with a command or by raising the acceleration input. In fast mode only the fast program and fast-exit commands are acted upon. The program engine follows flash semantics: it can only clear bits. A request that needs a 0 to become 1 stops early and raises the sticky error flag. Erase-all is the only way to set bits back to ones. All resets are synchronous and active-high. `rst` doubles as the hardware reset and aborts any running operation.

Top module: `flash_cmd_ctl`

## Requirements
- R1: After reset, busy_o and err_o are low and the decoder is in read mode, so a normal program sequence is accepted at once.
- R2: The writes 0xAA at address 0x555, 0x55 at 0x2AA, 0xA0 at 0x555 and then an address/data write store that data in the selected word. busy_o is high for PROG_CYCLES+3 cycles, starting in the cycle after the final write.
- R3: A wrong data byte or wrong address at any unlock or command step returns the decoder to read mode. A following address/data write then changes nothing.
- R4: The writes 0xAA at 0x555, 0x55 at 0x2AA and 0x10 at 0x555 set every word to all ones, with busy_o high for 2**ARR_AW+1 cycles.
- R5: Two unlock writes followed by 0x20 at 0x555 enter fast mode. There, a write of 0xA0 at any address followed by an address/data write programs a word, and this repeats without unlock writes.
- R6: In fast mode any write other than 0xA0 or 0x90 has no effect, and fast mode is kept.
- R7: In fast mode, 0x90 followed by 0x00 returns to normal read mode. If 0x90 is followed by any other value, fast mode is kept.
- R8: rd_data_o shows the word at rd_addr_i one cycle after the address is applied, both in normal and fast mode.
- R9: Writes that arrive while busy_o is high are ignored and do not change the decoder state.
- R10: A program request that needs any stored 0 bit to become 1 sets err_o, keeps busy_o high for only 3 cycles and leaves the word unchanged.
- R11: err_o stays set until a 0xF0 write in normal mode, a fast-mode exit sequence, or rst.
- R12: While acc_i is high the decoder is held in fast mode, and the exit sequence does not leave it. After acc_i falls, fast mode persists until the exit sequence.
- R13: rst aborts a running program operation: the word stays unchanged, busy_o and err_o go low and the decoder returns to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also the hardware abort |
| acc_i | input | 1 | Acceleration input, forces fast mode while high |
| wr_en_i | input | 1 | Host write strobe, one cycle per write |
| wr_addr_i | input | BUS_AW | Host write address |
| wr_data_i | input | DW | Host write data; the low byte carries commands |
| rd_addr_i | input | ARR_AW | Read word address |
| rd_data_o | output | DW | Registered read data |
| busy_o | output | 1 | Internal operation running |
| err_o | output | 1 | Sticky program failure flag |

## Verification
Every array word is programmed with an arithmetic pattern: a different single bit is cleared in each word, and the word index is cleared in the upper byte. A full read-back sweep then exposes stuck, aliased or misrouted words, which a single-address test would miss. The command sequences are also corrupted one step at a time, by a wrong data byte or a wrong address. This separates a decoder that checks each step from one that only counts writes. Fast mode is tried with foreign commands, with a broken exit, with the acceleration input and with a raise-a-bit request. These show whether the restricted command set, the mode stickiness and the sticky error are each kept apart from normal read mode. A reset in the middle of a program, and writes issued while busy, show that the array is touched only at the end of a completed operation.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    D_READ,
    D_UL1,
    D_UL2,
    D_PROG,
    D_BYP,
    D_BYP_PROG,
    D_BYP_RST
  } dec_state_t;

  typedef enum logic [2:0] {
    E_IDLE,
    E_FETCH,
    E_CHECK,
    E_TIME,
    E_ERASE
  } eng_state_t;

  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_FAST   = 8'h20;
  localparam logic [7:0] CMD_WIPE   = 8'h10;
  localparam logic [7:0] CMD_RDMODE = 8'hF0;
  localparam logic [7:0] CMD_FEXIT1 = 8'h90;
  localparam logic [7:0] CMD_FEXIT2 = 8'h00;

  localparam logic [10:0] KEY_ADDR_A = 11'h555;
  localparam logic [10:0] KEY_ADDR_B = 11'h2AA;

endpackage

// File: rtl/flash_word_array.sv
module flash_word_array #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    ra_data <= mem[ra_addr];
  end

  always_ff @(posedge clk) begin
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int BUS_AW = 11,
  parameter int DW     = 16,
  parameter int ARR_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              start_prog,
  output logic              start_erase,
  output logic              clr_err,
  output logic [ARR_AW-1:0] tgt_addr,
  output logic [DW-1:0]     tgt_data
);
  dec_state_t st, nxt;
  logic sp, se, ce;
  logic [7:0] cmd;
  logic at_a, at_b;

  function automatic logic is_fast(dec_state_t s);
    return (s == D_BYP) || (s == D_BYP_PROG) || (s == D_BYP_RST);
  endfunction

  assign cmd  = wr_data[7:0];
  assign at_a = (wr_addr == BUS_AW'(KEY_ADDR_A));
  assign at_b = (wr_addr == BUS_AW'(KEY_ADDR_B));

  always_comb begin
    nxt = st;
    sp  = 1'b0;
    se  = 1'b0;
    ce  = 1'b0;
    if (wr_en && !busy) begin
      case (st)
        D_READ: begin
          if (at_a && cmd == CMD_KEY1) nxt = D_UL1;
          else if (cmd == CMD_RDMODE) ce = 1'b1;
        end
        D_UL1: begin
          if (at_b && cmd == CMD_KEY2) nxt = D_UL2;
          else begin
            nxt = D_READ;
            ce  = (cmd == CMD_RDMODE);
          end
        end
        D_UL2: begin
          nxt = D_READ;
          if (at_a && cmd == CMD_PROG) nxt = D_PROG;
          else if (at_a && cmd == CMD_FAST) nxt = D_BYP;
          else if (at_a && cmd == CMD_WIPE) se = 1'b1;
          else ce = (cmd == CMD_RDMODE);
        end
        D_PROG: begin
          sp  = 1'b1;
          nxt = D_READ;
        end
        D_BYP: begin
          if (cmd == CMD_PROG) nxt = D_BYP_PROG;
          else if (cmd == CMD_FEXIT1) nxt = D_BYP_RST;
        end
        D_BYP_PROG: begin
          sp  = 1'b1;
          nxt = D_BYP;
        end
        D_BYP_RST: begin
          if (cmd == CMD_FEXIT2) begin
            nxt = D_READ;
            ce  = 1'b1;
          end else begin
            nxt = D_BYP;
          end
        end
        default: nxt = D_READ;
      endcase
    end
    if (acc && !is_fast(nxt)) nxt = D_BYP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= D_READ;
      start_prog  <= 1'b0;
      start_erase <= 1'b0;
      clr_err     <= 1'b0;
      tgt_addr    <= '0;
      tgt_data    <= '0;
    end else begin
      st          <= nxt;
      start_prog  <= sp;
      start_erase <= se;
      clr_err     <= ce;
      if (sp) begin
        tgt_addr <= wr_addr[ARR_AW-1:0];
        tgt_data <= wr_data;
      end
    end
  end

  AST_FAST_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (st == D_BYP && wr_en && !busy && cmd != CMD_PROG && cmd != CMD_FEXIT1)
      |=> (st == D_BYP)); // R6

  AST_ACC_FORCES_FAST: assert property (@(posedge clk) disable iff (rst)
    acc |=> is_fast(st)); // R12

  AST_BUSY_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (busy && !acc) |=> $stable(st)); // R9

  AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_prog, start_erase})); // R9

  AST_RESET_READ: assert property (@(posedge clk)
    rst |=> (st == D_READ && !start_prog && !start_erase)); // R13
endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
  import flash_cmd_pkg::*;
#(
  parameter int DW          = 16,
  parameter int AW          = 4,
  parameter int PROG_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_prog,
  input  logic          start_erase,
  input  logic          clr_err,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          err
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(PROG_CYCLES - 1);
  localparam logic [AW-1:0] IDX_LAST = AW'(DEPTH - 1);

  eng_state_t    est;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] idx;
  logic [DW-1:0] data_q;
  logic          raise_needed;

  assign raise_needed = |(data_q & ~mem_rdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      est    <= E_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      idx    <= '0;
      data_q <= '0;
      err    <= 1'b0;
    end else begin
      if (clr_err) err <= 1'b0;
      case (est)
        E_IDLE: begin
          if (start_prog) begin
            addr_q <= tgt_addr;
            data_q <= tgt_data;
            est    <= E_FETCH;
          end else if (start_erase) begin
            idx <= '0;
            est <= E_ERASE;
          end
        end
        E_FETCH: est <= E_CHECK;
        E_CHECK: begin
          if (raise_needed) begin
            err <= 1'b1;
            est <= E_IDLE;
          end else begin
            cnt <= '0;
            est <= E_TIME;
          end
        end
        E_TIME: begin
          if (cnt == CNT_LAST) est <= E_IDLE;
          else cnt <= cnt + 1'b1;
        end
        E_ERASE: begin
          if (idx == IDX_LAST) est <= E_IDLE;
          idx <= idx + 1'b1;
        end
        default: est <= E_IDLE;
      endcase
    end
  end

  assign mem_raddr = addr_q;
  assign mem_we    = !rst && ((est == E_TIME && cnt == CNT_LAST) || est == E_ERASE);
  assign mem_waddr = (est == E_ERASE) ? idx : addr_q;
  assign mem_wdata = (est == E_ERASE) ? {DW{1'b1}} : data_q;
  assign busy      = (est != E_IDLE);

  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (mem_we && est == E_TIME) |-> ((mem_wdata & ~mem_rdata) == '0)); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !clr_err) |=> err); // R11

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (start_prog || start_erase) |-> (est == E_IDLE)); // R9

  AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy); // R2
endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl #(
  parameter int BUS_AW      = 11,
  parameter int DW          = 16,
  parameter int ARR_AW      = 4,
  parameter int PROG_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_i,
  input  logic              wr_en_i,
  input  logic [BUS_AW-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [ARR_AW-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              busy_o,
  output logic              err_o
);
  logic              start_prog, start_erase, clr_err, eng_busy;
  logic [ARR_AW-1:0] tgt_addr, mem_raddr, mem_waddr;
  logic [DW-1:0]     tgt_data, mem_rdata, mem_wdata;
  logic              mem_we;

  assign busy_o = eng_busy | start_prog | start_erase;

  flash_cmd_decode #(.BUS_AW(BUS_AW), .DW(DW), .ARR_AW(ARR_AW)) u_dec (
    .clk(clk), .rst(rst), .acc(acc_i), .busy(busy_o),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .start_prog(start_prog), .start_erase(start_erase), .clr_err(clr_err),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data)
  );

  flash_prog_engine #(.DW(DW), .AW(ARR_AW), .PROG_CYCLES(PROG_CYCLES)) u_eng (
    .clk(clk), .rst(rst),
    .start_prog(start_prog), .start_erase(start_erase), .clr_err(clr_err),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .busy(eng_busy), .err(err_o)
  );

  flash_word_array #(.DW(DW), .AW(ARR_AW)) u_arr (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .ra_addr(rd_addr_i), .ra_data(rd_data_o),
    .rb_addr(mem_raddr), .rb_data(mem_rdata)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    rst |=> (!busy_o && !err_o)); // R1
endmodule

// File: tb/sim_flash_cmd_ctl.sv
module sim_flash_cmd_ctl;
  localparam int BUS_AW = 11;
  localparam int DW     = 16;
  localparam int ARR_AW = 4;
  localparam int P      = 8;
  localparam int DEPTH  = 1 << ARR_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc = 1'b0;
  logic wr_en = 1'b0;
  logic [BUS_AW-1:0] wr_addr = '0;
  logic [DW-1:0]     wr_data = '0;
  logic [ARR_AW-1:0] rd_addr = '0;
  logic [DW-1:0]     rd_data;
  logic busy, err;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flash_cmd_ctl #(.BUS_AW(BUS_AW), .DW(DW), .ARR_AW(ARR_AW), .PROG_CYCLES(P)) u0 (
    .clk(clk), .rst(rst), .acc_i(acc), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy), .err_o(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [BUS_AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    int n;
    busy_len(n);
  endtask

  task automatic rd_chk(input string req, input int a, input logic [DW-1:0] exp);
    @(negedge clk);
    rd_addr = ARR_AW'(a);
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  task automatic erase_all();
    unlock();
    wr(11'h555, 16'h0010);
    wait_idle();
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return ~((DW'(1) << i) | (DW'(i) << 8));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 err", err, 0);

    // R4 erase-all and its duration
    unlock();
    wr(11'h555, 16'h0010);
    busy_len(n);
    check("R4 erase busy cycles", n, DEPTH + 1);
    for (int i = 0; i < DEPTH; i++) rd_chk("R4 erased word", i, 16'hFFFF);

    // R2 normal program sweep over every word
    for (int i = 0; i < DEPTH; i++) begin
      unlock();
      wr(11'h555, 16'h00A0);
      wr(BUS_AW'(i), pat(i));
      busy_len(n);
      if (i == 0) check("R2 program busy cycles", n, P + 3);
    end
    for (int i = 0; i < DEPTH; i++) rd_chk("R2 programmed word", i, pat(i));
    check("R2 no error", err, 0);

    // R10 raising bits fails; R11 stickiness and clear by F0
    unlock();
    wr(11'h555, 16'h00A0);
    wr(11'h003, 16'hFFFF);
    busy_len(n);
    check("R10 short busy", n, 3);
    check("R10 err set", err, 1);
    rd_chk("R10 word unchanged", 3, pat(3));
    wr(11'h000, 16'h0033);
    repeat (3) @(negedge clk);
    check("R11 err sticky", err, 1);
    wr(11'h000, 16'h00F0);
    @(negedge clk);
    check("R11 cleared by F0", err, 0);

    // R3 corrupted sequences
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0056);
    wr(11'h005, 16'h0000);
    @(negedge clk);
    check("R3 bad key data no busy", busy, 0);
    rd_chk("R3 bad key data", 5, pat(5));
    unlock();
    wr(11'h554, 16'h00A0);
    wr(11'h005, 16'h0000);
    @(negedge clk);
    rd_chk("R3 bad command addr", 5, pat(5));
    wr(11'h555, 16'h00AA);
    wr(11'h2AB, 16'h0055);
    wr(11'h555, 16'h00A0);
    wr(11'h005, 16'h0000);
    @(negedge clk);
    rd_chk("R3 bad key addr", 5, pat(5));

    // R9 writes during busy ignored
    erase_all();
    unlock();
    wr(11'h555, 16'h00A0);
    wr(11'h006, 16'h0F0F);
    unlock();
    wr(11'h555, 16'h00A0);
    wait_idle();
    wr(11'h007, 16'h0000);
    @(negedge clk);
    check("R9 no busy after stray", busy, 0);
    rd_chk("R9 target written", 6, 16'h0F0F);
    rd_chk("R9 stray ignored", 7, 16'hFFFF);

    // R5 fast mode programming, R8 reads in fast mode
    unlock();
    wr(11'h555, 16'h0020);
    for (int i = 8; i < 12; i++) begin
      wr(11'h123, 16'h00A0);
      wr(BUS_AW'(i), pat(i));
      busy_len(n);
      if (i == 8) check("R5 fast busy cycles", n, P + 3);
    end
    for (int i = 8; i < 12; i++) rd_chk("R5 R8 fast word", i, pat(i));

    // R6 foreign writes ignored in fast mode
    wr(11'h000, 16'h00F0);
    wr(11'h555, 16'h0010);
    wr(11'h00D, 16'h1234);
    @(negedge clk);
    check("R6 no busy", busy, 0);
    rd_chk("R6 foreign ignored", 13, 16'hFFFF);
    wr(11'h000, 16'h00A0);
    wr(11'h00D, 16'h1234);
    wait_idle();
    rd_chk("R6 mode kept", 13, 16'h1234);

    // R7 broken and real exit, R11 exit clears err
    wr(11'h000, 16'h00A0);
    wr(11'h00E, 16'h00FF);
    wait_idle();
    wr(11'h000, 16'h00A0);
    wr(11'h00E, 16'hFFFF);
    wait_idle();
    check("R10 fast err", err, 1);
    wr(11'h000, 16'h0090);
    wr(11'h000, 16'h0005);
    wr(11'h000, 16'h00A0);
    wr(11'h00E, 16'h000F);
    wait_idle();
    rd_chk("R7 broken exit keeps mode", 14, 16'h000F);
    check("R11 err kept", err, 1);
    wr(11'h000, 16'h0090);
    wr(11'h000, 16'h0000);
    @(negedge clk);
    check("R11 cleared by exit", err, 0);
    wr(11'h000, 16'h00A0);
    wr(11'h00F, 16'h0000);
    @(negedge clk);
    rd_chk("R7 exited", 15, 16'hFFFF);

    // R12 acceleration input
    @(negedge clk);
    acc = 1'b1;
    repeat (2) @(negedge clk);
    wr(11'h000, 16'h00A0);
    wr(11'h00F, 16'hABCD);
    wait_idle();
    rd_chk("R12 acc fast program", 15, 16'hABCD);
    wr(11'h000, 16'h0090);
    wr(11'h000, 16'h0000);
    wr(11'h000, 16'h00A0);
    wr(11'h00F, 16'h0001);
    wait_idle();
    rd_chk("R12 exit blocked", 15, 16'h0001);
    acc = 1'b0;
    wr(11'h000, 16'h00A0);
    wr(11'h00F, 16'h0000);
    wait_idle();
    rd_chk("R12 fast kept after acc", 15, 16'h0000);
    wr(11'h000, 16'h0090);
    wr(11'h000, 16'h0000);

    // R13 hardware reset abort
    erase_all();
    unlock();
    wr(11'h555, 16'h00A0);
    wr(11'h002, 16'h0000);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R13 busy dropped", busy, 0);
    repeat (P + 4) @(negedge clk);
    rd_chk("R13 word unchanged", 2, 16'hFFFF);
    unlock();
    wr(11'h555, 16'h00A0);
    wr(11'h002, 16'h5A5A);
    wait_idle();
    rd_chk("R13 read mode after abort", 2, 16'h5A5A);
    unlock();
    wr(11'h555, 16'h00A0);
    wr(11'h002, 16'hFFFF);
    wait_idle();
    check("R13 err before reset", err, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R13 err cleared", err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule